// File: doc/BRIEF.md
# Audio Clock Divider Chain

This block produces an audio master clock and a serial bit clock for a transmit side and a receive side. Each side picks its root clock from one of two candidates: a system clock or an external oscillator. The selected clock then passes through a fixed halving stage, an optional divide-by-eight prescaler and a modulus divider programmable from 1 to 256, which together give the master clock. A second divider, programmable from 1 to 16, derives the bit clock from the master clock. Each side can instead route its selected root clock straight to the master clock.

Each side also has a direction control for the master-clock pin. When the pin is an output, the block drives its internally generated master clock onto it. When the pin is an input, the clock arriving on the pin feeds the bit-clock divider and the internal master-clock chain is ignored. All logic runs on one fast core clock `clk`. The root clocks and the master-clock pin inputs are sampled as levels, so every divider stage counts rising edges of its input. Each side holds one 16-bit configuration word, written through a single-cycle write strobe together with a side select.

Top module: `audio_clkdiv_top`

## Requirements
- R1: After reset both configuration words are zero. Each master-clock pin is an input, so `*_mclk_oe` and `*_mclk_o` are low, and each bit clock follows its side's master-clock pin input undivided.
- R2: With the pin set as an output and bypass off, the master clock is the selected root clock divided by 2 × P × M. M is the field in bits [7:0] plus one. Bit 13 selects the root: 0 means the system clock, 1 means the external oscillator.
- R3: Bit 12 set makes P = 8. Bit 12 clear makes P = 1.
- R4: Bit 14 set routes the selected root clock directly to the master clock, skipping the halving, prescaler and modulus stages.
- R5: The bit clock is its source divided by F, where F is the field in bits [11:8] plus one. A bit-clock rising edge in steady state follows a rising edge of the master clock.
- R6: Bit 15 sets the master-clock pin direction (1 = output, 0 = input). As an output, `*_mclk_oe` is high and `*_mclk_o` carries the internal master clock. As an input, `*_mclk_oe` and `*_mclk_o` are low and the pin input `*_mclk_i` feeds the bit-clock divider.
- R7: A stage dividing by N ≥ 2 stays high for floor(N/2) periods of its input and low for the rest of its period, so odd ratios have a high phase one input period shorter than the low phase. A stage with N = 1 passes its input level through.
- R8: A new divider setting is taken up only when that stage reaches its terminal count. The period in progress finishes at its old length, and in steady state no output phase is shorter than two core cycles.
- R9: `cfg_side` selects the word that a write changes (0 = transmit, 1 = receive). A write to one side leaves the other side's outputs unchanged.
- R10: The largest modulus, field value 255 (M = 256), divides correctly, giving a master-clock ratio of 512 without the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; samples the clock inputs and runs all dividers |
| rst_n | input | 1 | Active-low asynchronous reset |
| sys_clk_i | input | 1 | System root clock level |
| ext_osc_i | input | 1 | External oscillator root clock level |
| tx_mclk_i | input | 1 | Transmit master-clock pin input level |
| rx_mclk_i | input | 1 | Receive master-clock pin input level |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_side | input | 1 | Side written: 0 transmit, 1 receive |
| cfg_wdata | input | 16 | Configuration word |
| tx_mclk_o | output | 1 | Transmit master clock driven out |
| tx_mclk_oe | output | 1 | Transmit master-clock pin output enable |
| tx_bclk_o | output | 1 | Transmit bit clock |
| rx_mclk_o | output | 1 | Receive master clock driven out |
| rx_mclk_oe | output | 1 | Receive master-clock pin output enable |
| rx_bclk_o | output | 1 | Receive bit clock |

## Verification
The properties assume that every clock input holds each level for at least two core cycles. Under that assumption, a sampled edge is never lost and a passed-through phase is never shorter than two cycles. They also assume that switching source, bypass or direction may glitch, so the runt and edge-order checks apply only once three cycles have passed without a configuration write. The stimulus toggles the root clocks every two and three core cycles and the pin inputs every five and seven, always at the falling edge of `clk`. Every measurement waits several output periods after a write, except the one deliberate mid-period change that checks R8.

// File: rtl/audclk_pkg.sv
package audclk_pkg;
    localparam int NSIDE   = 2;
    localparam int MW      = 8;
    localparam int FW      = 4;
    localparam int PRE_DIV = 8;
    localparam int PW      = $clog2(PRE_DIV);
    localparam int CFG_W   = MW + FW + 4;
    localparam int NSRC    = 2 + NSIDE;

    typedef struct packed {
        logic          mclk_out;
        logic          bypass;
        logic          src_ext;
        logic          pre_en;
        logic [FW-1:0] fdiv_m1;
        logic [MW-1:0] mdiv_m1;
    } side_cfg_t;
endpackage

// File: rtl/edge_sampler.sv
module edge_sampler #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] rise_o
);
    typedef struct packed {
        logic [N-1:0] cur;
        logic [N-1:0] prev;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d      = smp_q;
        smp_d.cur  = raw_i;
        smp_d.prev = smp_q.cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '0;
        else        smp_q <= smp_d;
    end

    assign lvl_o  = smp_q.cur;
    assign rise_o = smp_q.cur & ~smp_q.prev;
endmodule

// File: rtl/clkdiv_stage.sv
module clkdiv_stage #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_lvl,
    input  logic          in_rise,
    input  logic [CW-1:0] ratio_m1,
    output logic          out_lvl,
    output logic          out_rise
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] act;
        logic          lvl;
        logic          rise;
    } st_t;

    st_t st_d, st_q;
    logic [CW:0] half_cur;
    logic [CW:0] cnt_nxt;

    always_comb begin
        st_d     = st_q;
        half_cur = ({1'b0, st_q.act} + (CW+1)'(1)) >> 1;
        cnt_nxt  = {1'b0, st_q.cnt} + (CW+1)'(1);
        if (in_rise) begin
            if (st_q.cnt == st_q.act) begin
                // terminal count: start a new period, take up the new ratio
                st_d.cnt = '0;
                st_d.act = ratio_m1;
                st_d.lvl = 1'b1;
            end else begin
                st_d.cnt = cnt_nxt[CW-1:0];
                st_d.lvl = (cnt_nxt < half_cur);
            end
        end else if (st_q.act == '0) begin
            st_d.lvl = in_lvl;
        end
        st_d.rise = st_d.lvl & ~st_q.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_lvl  = st_q.lvl;
    assign out_rise = st_q.rise;
endmodule

// File: rtl/clkchain_side.sv
module clkchain_side
    import audclk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  side_cfg_t cfg,
    input  logic      sys_lvl,
    input  logic      sys_rise,
    input  logic      ext_lvl,
    input  logic      ext_rise,
    input  logic      pin_lvl,
    input  logic      pin_rise,
    output logic      mclk_o,
    output logic      mclk_oe,
    output logic      bclk_o
);
    logic src_lvl, src_rise;
    logic h_lvl, h_rise;
    logic p_lvl, p_rise;
    logic m_lvl, m_rise;
    logic mi_lvl, mi_rise;
    logic b_lvl, b_rise;
    logic f_lvl, f_rise;
    logic [PW-1:0] pre_m1;

    always_comb begin
        src_lvl  = cfg.src_ext ? ext_lvl  : sys_lvl;
        src_rise = cfg.src_ext ? ext_rise : sys_rise;
        pre_m1   = cfg.pre_en ? PW'(PRE_DIV - 1) : '0;
    end

    clkdiv_stage #(.CW(1)) u_half (
        .clk(clk), .rst_n(rst_n), .in_lvl(src_lvl), .in_rise(src_rise),
        .ratio_m1(1'b1), .out_lvl(h_lvl), .out_rise(h_rise)
    );

    clkdiv_stage #(.CW(PW)) u_pre (
        .clk(clk), .rst_n(rst_n), .in_lvl(h_lvl), .in_rise(h_rise),
        .ratio_m1(pre_m1), .out_lvl(p_lvl), .out_rise(p_rise)
    );

    clkdiv_stage #(.CW(MW)) u_mod (
        .clk(clk), .rst_n(rst_n), .in_lvl(p_lvl), .in_rise(p_rise),
        .ratio_m1(cfg.mdiv_m1), .out_lvl(m_lvl), .out_rise(m_rise)
    );

    always_comb begin
        mi_lvl  = cfg.bypass ? src_lvl  : m_lvl;
        mi_rise = cfg.bypass ? src_rise : m_rise;
        b_lvl   = cfg.mclk_out ? mi_lvl  : pin_lvl;
        b_rise  = cfg.mclk_out ? mi_rise : pin_rise;
    end

    clkdiv_stage #(.CW(FW)) u_bit (
        .clk(clk), .rst_n(rst_n), .in_lvl(b_lvl), .in_rise(b_rise),
        .ratio_m1(cfg.fdiv_m1), .out_lvl(f_lvl), .out_rise(f_rise)
    );

    assign mclk_oe = cfg.mclk_out;
    assign mclk_o  = cfg.mclk_out & mi_lvl;
    assign bclk_o  = f_lvl;

    logic unused_ok;
    assign unused_ok = f_rise;
endmodule

// File: rtl/audio_clkdiv_top.sv
module audio_clkdiv_top
    import audclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sys_clk_i,
    input  logic             ext_osc_i,
    input  logic             tx_mclk_i,
    input  logic             rx_mclk_i,
    input  logic             cfg_we,
    input  logic             cfg_side,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             tx_mclk_o,
    output logic             tx_mclk_oe,
    output logic             tx_bclk_o,
    output logic             rx_mclk_o,
    output logic             rx_mclk_oe,
    output logic             rx_bclk_o
);
    side_cfg_t [NSIDE-1:0] cfg_d, cfg_q;
    logic [NSRC-1:0] raw, lvl, rise;
    logic [NSIDE-1:0] mclk_w, oe_w, bclk_w;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) cfg_d[cfg_side] = side_cfg_t'(cfg_wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign raw = {rx_mclk_i, tx_mclk_i, ext_osc_i, sys_clk_i};

    edge_sampler #(.N(NSRC)) u_smp (
        .clk(clk), .rst_n(rst_n), .raw_i(raw), .lvl_o(lvl), .rise_o(rise)
    );

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        clkchain_side u_side (
            .clk(clk), .rst_n(rst_n), .cfg(cfg_q[g]),
            .sys_lvl(lvl[0]), .sys_rise(rise[0]),
            .ext_lvl(lvl[1]), .ext_rise(rise[1]),
            .pin_lvl(lvl[2+g]), .pin_rise(rise[2+g]),
            .mclk_o(mclk_w[g]), .mclk_oe(oe_w[g]), .bclk_o(bclk_w[g])
        );
    end

    assign tx_mclk_o  = mclk_w[0];
    assign tx_mclk_oe = oe_w[0];
    assign tx_bclk_o  = bclk_w[0];
    assign rx_mclk_o  = mclk_w[1];
    assign rx_mclk_oe = oe_w[1];
    assign rx_bclk_o  = bclk_w[1];
endmodule

// File: rtl/audclk_chk.sv
module audclk_chk
    import audclk_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic             cfg_side,
    input logic [CFG_W-1:0] cfg_wdata,
    input logic             tx_mclk_o,
    input logic             tx_mclk_oe,
    input logic             tx_bclk_o,
    input logic             rx_mclk_o,
    input logic             rx_mclk_oe,
    input logic             rx_bclk_o
);
    logic [1:0] quiet_q;
    logic       calm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           quiet_q <= '0;
        else if (cfg_we)      quiet_q <= '0;
        else if (quiet_q != 2'd3) quiet_q <= quiet_q + 2'd1;
    end
    assign calm = (quiet_q == 2'd3) && !cfg_we;

    // R6
    oe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_side && cfg_wdata[CFG_W-1]) |=> tx_mclk_oe);

    // R6
    mclk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_mclk_oe |-> !tx_mclk_o) and (!rx_mclk_oe |-> !rx_mclk_o));

    // R9
    rx_wr_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_side) |=> $stable(tx_mclk_oe));

    // R8
    tx_bclk_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (calm && $rose(tx_bclk_o)) |=> tx_bclk_o);

    // R8
    tx_bclk_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (calm && $fell(tx_bclk_o)) |=> !tx_bclk_o);

    // R8
    rx_bclk_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (calm && $rose(rx_bclk_o)) |=> rx_bclk_o);

    // R8
    tx_mclk_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (calm && $rose(tx_mclk_o)) |=> tx_mclk_o);

    // R5
    bclk_after_mclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (calm && $rose(tx_bclk_o) && $past(tx_mclk_oe)) |->
        ($past(tx_mclk_o) && !$past(tx_mclk_o, 2)));
endmodule

bind audio_clkdiv_top audclk_chk u_chk (.*);

// File: tb/sim_audio_clkdiv_top.sv
module sim_audio_clkdiv_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sys_clk_i = 1'b0, ext_osc_i = 1'b0, tx_mclk_i = 1'b0, rx_mclk_i = 1'b0;
    logic cfg_we = 1'b0, cfg_side = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic tx_mclk_o, tx_mclk_oe, tx_bclk_o, rx_mclk_o, rx_mclk_oe, rx_bclk_o;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    typedef struct {
        int    side;
        bit    chk_m;
        int    mper, mhi, bper, bhi;
        string tag;
    } exp_t;
    exp_t exq[$];

    audio_clkdiv_top u0 (.*);

    always #10 clk = ~clk;

    initial forever begin repeat (2) @(negedge clk); sys_clk_i = ~sys_clk_i; end
    initial forever begin repeat (3) @(negedge clk); ext_osc_i = ~ext_osc_i; end
    initial forever begin repeat (5) @(negedge clk); tx_mclk_i = ~tx_mclk_i; end
    initial forever begin repeat (7) @(negedge clk); rx_mclk_i = ~rx_mclk_i; end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog (all requirements): actual %0d cycles expected < 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    function automatic logic sig(int side, int which);
        if (side == 0) return which == 0 ? tx_mclk_o : tx_bclk_o;
        return which == 0 ? rx_mclk_o : rx_bclk_o;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // apply one stage of ratio n to a clock described by period/high (R7)
    function automatic void stage(input int n, inout int per, inout int hi);
        if (n > 1) begin
            hi  = (n / 2) * per;
            per = n * per;
        end
    endfunction

    task automatic measure(input int side, input int which, output int per, output int hi);
        logic prev;
        int   n;
        n = 0;
        prev = sig(side, which);
        while (n < 4) begin
            @(negedge clk);
            if (!prev && sig(side, which)) n++;
            prev = sig(side, which);
        end
        hi = 0;
        while (sig(side, which)) begin @(negedge clk); hi++; end
        per = hi;
        while (!sig(side, which)) begin @(negedge clk); per++; end
    endtask

    task automatic wr(input int side, input logic [15:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_side = side[0]; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // driver: optionally writes a word, then queues the expected clocks
    task automatic apply(input int side, input bit wr_en, input bit oe, input bit byp,
                         input bit ext, input bit pre, input int m, input int f,
                         input string tag);
        exp_t e;
        int   per, hi;
        if (wr_en)
            wr(side, {oe, byp, ext, pre, 4'(f - 1), 8'(m - 1)});
        per = ext ? 6 : 4;
        hi  = per / 2;
        if (!byp) begin
            stage(2, per, hi);
            stage(pre ? 8 : 1, per, hi);
            stage(m, per, hi);
        end
        e.side = side; e.chk_m = oe; e.mper = per; e.mhi = hi; e.tag = tag;
        if (!oe) begin
            per = (side == 0) ? 10 : 14;
            hi  = per / 2;
        end
        stage(f, per, hi);
        e.bper = per; e.bhi = hi;
        exq.push_back(e);
        while (exq.size() != 0) @(negedge clk);
    endtask

    // monitor: pops each expected item and compares measured waveforms
    initial forever begin
        @(negedge clk);
        if (exq.size() != 0) begin
            exp_t e;
            int   p, h;
            e = exq[0];
            if (e.chk_m) begin
                measure(e.side, 0, p, h);
                check({e.tag, " mclk period"}, p, e.mper);
                check({e.tag, " mclk high"}, h, e.mhi);
            end
            measure(e.side, 1, p, h);
            check({e.tag, " bclk period"}, p, e.bper);
            check({e.tag, " bclk high"}, h, e.bhi);
            void'(exq.pop_front());
        end
    end

    initial begin
        int cnt, hi;
        logic prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 tx_mclk_oe", tx_mclk_oe, 0);
        check("R1 tx_mclk_o", tx_mclk_o, 0);
        check("R1 rx_mclk_oe", rx_mclk_oe, 0);
        apply(0, 0, 0, 0, 0, 0, 1, 1, "R1 tx");
        apply(1, 0, 0, 0, 0, 0, 1, 1, "R1 rx");

        apply(0, 1, 1, 0, 0, 0, 3, 2, "R2");
        check("R6 tx_mclk_oe", tx_mclk_oe, 1);
        apply(0, 1, 1, 0, 1, 0, 2, 3, "R7");
        apply(0, 1, 1, 0, 0, 1, 1, 1, "R3");
        apply(0, 1, 1, 1, 1, 0, 5, 4, "R4");
        apply(1, 1, 1, 0, 0, 0, 256, 1, "R10");
        apply(1, 1, 0, 0, 0, 0, 1, 5, "R6");
        check("R6 rx_mclk_oe", rx_mclk_oe, 0);
        check("R6 rx_mclk_o", rx_mclk_o, 0);
        apply(0, 0, 1, 1, 1, 0, 5, 4, "R9");
        apply(0, 1, 1, 0, 0, 0, 1, 16, "R5");

        // R8: change F mid-period; the running period keeps its old length
        prev = tx_bclk_o;
        while (!( !prev && tx_bclk_o)) begin prev = tx_bclk_o; @(negedge clk); end
        wr(0, {1'b1, 1'b0, 1'b0, 1'b0, 4'd1, 8'd0});
        cnt = 2;
        prev = tx_bclk_o;
        while (!( !prev && tx_bclk_o)) begin prev = tx_bclk_o; @(negedge clk); cnt++; end
        check("R8 old period completes", cnt, 128);
        hi = 0;
        while (tx_bclk_o) begin @(negedge clk); hi++; end
        check("R8 new high phase", hi, 8);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule